// File: doc/BRIEF.md
# March Y Memory Self-Test Sequencer

This block is a built-in self-test controller for a small synchronous single-port RAM. When pulsed to start, it sweeps the RAM four times in the March Y order. First it writes zero to every cell. Next it makes an ascending pass that reads zero, writes ones and reads ones at each cell. Then a descending pass reads ones, writes zero and reads zero. Last comes an ascending pass that reads zero. It issues one memory command per clock, with the address, the write enable or read strobe, and a write value that is all zeros or all ones.

The RAM returns read data one cycle after the read strobe. The controller compares each returned word against the expected background in that cycle. On the first mismatch it latches a fail flag and the failing address. The march always runs to the end. A one-cycle done pulse then marks that the verdict is final, and the controller waits idle for the next start.

Top module: `march_bist_ctrl`

## Requirements
- R1: After a synchronous active-low reset, done, test_fail, fail_addr, mem_we and mem_rd are all zero.
- R2: In the clock cycle after start is sampled high in idle, the first element begins. It writes the all-zeros word to every address, ascending from 0, with one write per cycle.
- R3: The second element visits addresses 0 up to 2^ADDR_W-1. At each address it issues, in consecutive cycles, a read expecting 0, a write of all ones, and a read expecting all ones.
- R4: The third element visits addresses 2^ADDR_W-1 down to 0. At each address it issues a read expecting all ones, a write of all zeros, and a read expecting 0.
- R5: The fourth element reads every address in ascending order, expecting the all-zeros word.
- R6: mem_we and mem_rd are never high together. Every written word is either all zeros or all ones.
- R7: Each read result is compared in the cycle after its strobe. The first mismatch sets test_fail and records that read's address in fail_addr. Later mismatches leave both unchanged, and the march continues to its last command.
- R8: The command stream lasts exactly 8*2^ADDR_W cycles. No command is issued in the following cycle. done is high for exactly one cycle, two cycles after the final read strobe, and test_fail and fail_addr are final while done is high.
- R9: A start pulse during a march has no effect on the command stream. A start accepted in idle clears test_fail and sets fail_addr to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a march when idle |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after mem_rd |
| done | output | 1 | One-cycle pulse: march finished, verdict final |
| test_fail | output | 1 | At least one read mismatched |
| fail_addr | output | ADDR_W | Address of the first mismatching read |
| mem_addr | output | ADDR_W | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_rd | output | 1 | RAM read strobe |
| mem_wdata | output | DATA_W | RAM write data |

## Verification
A wrong element counter, operation index or address direction changes the command stream at once. The bench compares every command against its own reference list, so such an error shows up in the same cycle it appears. A wrong expected value in the comparator, or a failure to latch, only shows in test_fail and fail_addr at the done pulse. The faulty-memory runs are therefore chosen so that the first mismatch falls in either the ascending or the descending element, and each run predicts a different failing address. A broken end-of-element test shows as a stream whose length is wrong or a done pulse that comes early or late.

// File: rtl/march_pkg.sv
// Package: shared state type and the per-element operation table of the
// march sequence. Element index 0..3, operation index 0..2 within a cell.
package march_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_FIN   = 2'd3
    } march_state_e;

    // Number of operations applied to each cell in an element
    function automatic logic [1:0] elem_ops(input logic [1:0] elem);
        return (elem == 2'd1 || elem == 2'd2) ? 2'd3 : 2'd1;
    endfunction

    // True when the operation is a write (otherwise a read)
    function automatic logic op_is_write(input logic [1:0] elem, input logic [1:0] opi);
        if (elem == 2'd0) return 1'b1;
        if (elem == 2'd3) return 1'b0;
        return (opi == 2'd1);
    endfunction

    // Background value written or expected (0 = all zeros, 1 = all ones)
    function automatic logic op_value(input logic [1:0] elem, input logic [1:0] opi);
        case (elem)
            2'd1:    return (opi != 2'd0);
            2'd2:    return (opi == 2'd0);
            default: return 1'b0;
        endcase
    endfunction

    // Only the third element walks downward
    function automatic logic elem_down(input logic [1:0] elem);
        return (elem == 2'd2);
    endfunction

endpackage

// File: rtl/march_addr_gen.sv
// Address counter for the march sweep.
// Assumes: load and step are never high together; DEPTH is a power of two.
module march_addr_gen #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_down,
    input  logic              step,
    input  logic              down,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    // Load the start of an element or move one cell in its direction
    always_ff @(posedge clk) begin
        if (!rst_n)      addr <= '0;
        else if (load)   addr <= load_down ? TOP_ADDR : '0;
        else if (step)   addr <= down ? addr - 1'b1 : addr + 1'b1;
    end

    AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> addr != $past(addr)); // R3

endmodule

// File: rtl/march_seq.sv
// Sequencer: tracks element, operation within a cell and run state, and
// decides when the address counter loads or steps.
// Assumes: addr comes from march_addr_gen driven by load/step below.
module march_seq #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    output logic              load,
    output logic              load_down,
    output logic              step,
    output logic              down,
    output logic              run,
    output logic              op_write,
    output logic              op_bit,
    output logic              clr,
    output logic              fin
);
    import march_pkg::*;

    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    march_state_e state;
    logic [1:0]   elem;
    logic [1:0]   opi;
    logic         cell_done;
    logic         at_end;

    // Decode of the current position in the march
    always_comb begin
        run       = (state == ST_RUN);
        down      = elem_down(elem);
        cell_done = (opi == elem_ops(elem) - 2'd1);
        at_end    = down ? (addr == '0) : (addr == TOP_ADDR);
        op_write  = op_is_write(elem, opi);
        op_bit    = op_value(elem, opi);
        clr       = (state == ST_IDLE) && start;
        step      = run && cell_done && !at_end;
        load      = clr || (run && cell_done && at_end && elem != 2'd3);
        load_down = run && elem_down(elem + 2'd1);
        fin       = (state == ST_FIN);
    end

    // State, element and operation index update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            elem  <= 2'd0;
            opi   <= 2'd0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_RUN;
                    elem  <= 2'd0;
                    opi   <= 2'd0;
                end
                ST_RUN: begin
                    if (!cell_done) begin
                        opi <= opi + 2'd1;
                    end else begin
                        opi <= 2'd0;
                        if (at_end) begin
                            if (elem == 2'd3) state <= ST_DRAIN;
                            else              elem  <= elem + 2'd1;
                        end
                    end
                end
                ST_DRAIN: state <= ST_FIN;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    AST_OP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> opi < elem_ops(elem)); // R3
    AST_DRAIN_TO_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DRAIN |=> fin); // R8

endmodule

// File: rtl/march_cmp.sv
// Read checker: remembers the expected background and address of a read,
// compares the returned word a cycle later, and latches the first failure.
// Assumes: the RAM has exactly one cycle of read latency.
module march_cmp #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rd_issue,
    input  logic              rd_bit,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rdata,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);
    logic              pend;
    logic              pend_bit;
    logic [ADDR_W-1:0] pend_addr;
    logic              mismatch;

    // Capture what the outstanding read should return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_bit  <= 1'b0;
            pend_addr <= '0;
        end else begin
            pend      <= rd_issue;
            pend_bit  <= rd_bit;
            pend_addr <= rd_addr;
        end
    end

    // Compare returned data against the replicated background bit
    always_comb mismatch = pend && (rdata != {DATA_W{pend_bit}});

    // Sticky first-failure record, cleared when a new march starts
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fail      <= 1'b0;
            fail_addr <= '0;
        end else if (mismatch && !fail) begin
            fail      <= 1'b1;
            fail_addr <= pend_addr;
        end
    end

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fail && !clr |=> fail); // R7
    AST_FAIL_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fail && !clr |=> $stable(fail_addr)); // R7

endmodule

// File: rtl/march_bist_ctrl.sv
// Top of the March Y self-test controller: joins the sequencer, the address
// counter and the read checker, and drives the RAM command port.
// Assumes: a single-port synchronous RAM of 2**ADDR_W words, one-cycle read.
module march_bist_ctrl #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              test_fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_rd,
    output logic [DATA_W-1:0] mem_wdata
);
    logic load, load_down, step, down, run, op_write, op_bit, clr, fin;
    logic [ADDR_W-1:0] addr;

    march_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr),
        .load(load), .load_down(load_down), .step(step), .down(down),
        .run(run), .op_write(op_write), .op_bit(op_bit), .clr(clr), .fin(fin)
    );

    march_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .load_down(load_down),
        .step(step), .down(down), .addr(addr)
    );

    march_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .clr(clr), .rd_issue(mem_rd),
        .rd_bit(op_bit), .rd_addr(addr), .rdata(mem_rdata),
        .fail(test_fail), .fail_addr(fail_addr)
    );

    // RAM command port driven only while a march runs
    always_comb begin
        mem_addr  = addr;
        mem_we    = run && op_write;
        mem_rd    = run && !op_write;
        mem_wdata = {DATA_W{op_bit}};
        done      = fin;
    end

    AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_rd)); // R6
    AST_WDATA_SOLID: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == '0 || mem_wdata == '1)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_QUIET_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we && !mem_rd); // R8

endmodule

// File: tb/march_bist_ctrl_test.sv
`timescale 1ns/1ps
module march_bist_ctrl_test;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    typedef struct {
        bit we;
        int addr;
        bit val;
        int elem;
    } op_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [DW-1:0] mem_rdata;
    logic done, test_fail, mem_we, mem_rd;
    logic [AW-1:0] fail_addr, mem_addr;
    logic [DW-1:0] mem_wdata;

    logic [DW-1:0] ram [DEPTH];
    logic [DW-1:0] s1 [DEPTH];
    logic [DW-1:0] s0 [DEPTH];
    logic [DW-1:0] tf [DEPTH];

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    march_bist_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mem_rdata(mem_rdata),
        .done(done), .test_fail(test_fail), .fail_addr(fail_addr),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_rd(mem_rd), .mem_wdata(mem_wdata)
    );

    // Behavioural RAM with stuck-at and failed-falling-transition faults
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata | (ram[mem_addr] & tf[mem_addr]);
        if (mem_rd) mem_rdata <= (ram[mem_addr] | s1[mem_addr]) & ~s0[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_faults();
        for (int i = 0; i < DEPTH; i++) begin
            s1[i] = '0; s0[i] = '0; tf[i] = '0;
        end
    endtask

    // Reference: build the op list and predict the verdict
    task automatic run_march(input int poke, input string tag);
        op_t q[$];
        logic [DW-1:0] mm [DEPTH];
        bit efail = 0;
        int eaddr = 0;
        for (int a = 0; a < DEPTH; a++) q.push_back('{1, a, 0, 2});
        for (int a = 0; a < DEPTH; a++) begin
            q.push_back('{0, a, 0, 3}); q.push_back('{1, a, 1, 3}); q.push_back('{0, a, 1, 3});
        end
        for (int a = DEPTH - 1; a >= 0; a--) begin
            q.push_back('{0, a, 1, 4}); q.push_back('{1, a, 0, 4}); q.push_back('{0, a, 0, 4});
        end
        for (int a = 0; a < DEPTH; a++) q.push_back('{0, a, 0, 5});
        for (int a = 0; a < DEPTH; a++) mm[a] = ram[a];
        foreach (q[i]) begin
            logic [DW-1:0] v = q[i].val ? '1 : '0;
            if (q[i].we) mm[q[i].addr] = v | (mm[q[i].addr] & tf[q[i].addr]);
            else if (!efail && (((mm[q[i].addr] | s1[q[i].addr]) & ~s0[q[i].addr]) != v)) begin
                efail = 1; eaddr = q[i].addr;
            end
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        foreach (q[i]) begin
            logic [DW-1:0] v = q[i].val ? '1 : '0;
            bit ok = (mem_we == q[i].we) && (mem_rd == !q[i].we) &&
                     (int'(mem_addr) == q[i].addr) && (!q[i].we || mem_wdata == v) && !done;
            string rq = (q[i].elem == 2) ? "R2" : (q[i].elem == 3) ? "R3" :
                        (q[i].elem == 4) ? "R4" : "R5";
            chk(ok, {rq, " ", tag, " command"}, {mem_we, mem_rd, 2'b0, mem_addr, mem_wdata},
                {q[i].we, !q[i].we, 2'b0, AW'(q[i].addr), q[i].we ? v : mem_wdata});
            chk(!(mem_we && mem_rd), {"R6 ", tag}, {mem_we, mem_rd}, 2'b0);
            if (i == poke) start = 1'b1;   // R9: ignored while running
            @(negedge clk); start = 1'b0;
        end
        chk(!mem_we && !mem_rd && !done, {"R8 ", tag, " quiet after stream"}, {mem_we, mem_rd, done}, 3'b0);
        @(negedge clk);
        chk(done, {"R8 ", tag, " done pulse"}, done, 1);
        chk(test_fail == efail, {"R7 ", tag, " fail flag"}, test_fail, efail);
        chk(int'(fail_addr) == eaddr, {"R7 ", tag, " fail address"}, fail_addr, eaddr);
        @(negedge clk);
        chk(!done && !mem_we && !mem_rd, {"R8 ", tag, " back to idle"}, {done, mem_we, mem_rd}, 3'b0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) ram[i] = '0;
        clear_faults();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!done && !test_fail && fail_addr == '0 && !mem_we && !mem_rd, "R1 reset",
            {done, test_fail, mem_we, mem_rd, fail_addr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_we && !mem_rd, "R1 idle after reset", {done, mem_we, mem_rd}, 0);

        run_march(-1, "clean");
        s1[5] = 8'h08;                       // stuck-at-1: first seen ascending
        run_march(-1, "stuck1@5");
        clear_faults();
        s0[13] = 8'h01; s1[9] = 8'h80;
        run_march(-1, "two stuck");
        clear_faults();
        tf[3] = 8'h04; tf[11] = 8'h20;       // falling-write faults: seen descending
        run_march(-1, "fall faults");
        clear_faults();
        run_march(40, "R9 restart clean");   // fail cleared by accepted start
        chk(!test_fail, "R9 cleared verdict", test_fail, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule